// File: doc/BRIEF.md
# Keyboard and Display Register Interface

This block sits on a simple processor load/store bus and gives software a small window of byte-wide registers for one keyboard input stream and one display output stream. A character arriving from the keyboard side is latched into a data register and raises an input-ready flag. The display side has an output-ready flag that tells software the previous character has been fully shown. Software can poll these flags or let the block raise an interrupt.

Each device has a status register, a data register and a control register. All of them sit on word-aligned addresses inside a fixed window. Reading a status register clears that device's ready flag as a side effect. With a per-device enable bit set, that read also withdraws the interrupt request, so it serves as the acknowledge. A store to the display data register starts a new character: the block pulses a one-cycle strobe toward the display and waits for the display's done handshake before reporting ready again.

Addresses are 0x4000 for keyboard data, 0x4004 for keyboard status, 0x4008 for keyboard control, 0x4010 for display data, 0x4014 for display status and 0x4018 for display control.

Top module: `kbd_disp_if`

## Requirements
- R1: After reset the input-ready flag is 0, the output-ready flag is 1, both enable bits are 0, both data registers are 0, read data is 0 and the interrupt line is low.
- R2: A cycle with `kbd_valid` high stores `kbd_char` in the keyboard data register (read at 0x4000) and sets the input-ready flag. The flag is returned in bit 1 of 0x4004.
- R3: A read of 0x4004 returns the input-ready flag in bit 1 with all other bits 0, and clears the flag after that cycle.
- R4: When a keyboard arrival and a read of 0x4004 fall in the same cycle, the read returns the old flag value and the flag is set afterwards.
- R5: A store to 0x4010 loads the display data register, which drives `disp_char`. `disp_strobe` is high in the cycle after the store and falls again unless another store follows. The store clears the output-ready flag.
- R6: `disp_done` sets the output-ready flag, returned in bit 2 of 0x4014. If a store to 0x4010 happens in the same cycle, the store wins and the flag ends up 0.
- R7: A read of 0x4014 returns the output-ready flag in bit 2 with all other bits 0, and clears the flag. If `disp_done` is high in the same cycle, the flag stays set.
- R8: Bit 1 of a store to 0x4008 sets the keyboard enable, and bit 1 of a store to 0x4018 sets the display enable. Reading either address returns the enable in bit 1 with all other bits 0.
- R9: `irq` equals (input-ready AND keyboard enable) OR (output-ready AND display enable), taken from the register state of the current cycle.
- R10: Read data is registered. It appears on `bus_rdata` in the cycle after the read and holds until the next read. Reads of unmapped addresses return 0. Stores to status registers, to the keyboard data register or to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_rd | input | 1 | Load request this cycle |
| bus_wr | input | 1 | Store request this cycle |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Registered load data |
| kbd_valid | input | 1 | New keyboard character strobe |
| kbd_char | input | 8 | Keyboard character |
| disp_char | output | 8 | Character presented to the display |
| disp_strobe | output | 1 | One-cycle start pulse for the display |
| disp_done | input | 1 | Display finished the previous character |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover the reset state and each same-cycle collision: an arrival against a status read, done against a status read, and done against a display store. Each collision has exactly one correct winner, so each separates the intended priority from its reverse. A seeded random run then mixes arrivals, done pulses, loads and stores across mapped and unmapped addresses. A bench model compares read data, the display outputs and `irq` every cycle. This exposes a flag that clears on the wrong register, an enable decoded from the wrong bit, or read data that fails to hold between loads.

// File: rtl/kdi_pkg.sv
package kdi_pkg;
   localparam int unsigned OFS_KDATA = 'h00;
   localparam int unsigned OFS_KSTAT = 'h04;
   localparam int unsigned OFS_KCTL  = 'h08;
   localparam int unsigned OFS_DDATA = 'h10;
   localparam int unsigned OFS_DSTAT = 'h14;
   localparam int unsigned OFS_DCTL  = 'h18;

   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_KDATA = 3'd1,
      SEL_KSTAT = 3'd2,
      SEL_KCTL  = 3'd3,
      SEL_DDATA = 3'd4,
      SEL_DSTAT = 3'd5,
      SEL_DCTL  = 3'd6
   } kdi_sel_e;
endpackage

// File: rtl/kdi_decode.sv
module kdi_decode
   import kdi_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000
) (
   input  logic [ADDR_W-1:0] addr,
   output kdi_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_KDATA = BASE_ADDR + ADDR_W'(OFS_KDATA);
   localparam logic [ADDR_W-1:0] A_KSTAT = BASE_ADDR + ADDR_W'(OFS_KSTAT);
   localparam logic [ADDR_W-1:0] A_KCTL  = BASE_ADDR + ADDR_W'(OFS_KCTL);
   localparam logic [ADDR_W-1:0] A_DDATA = BASE_ADDR + ADDR_W'(OFS_DDATA);
   localparam logic [ADDR_W-1:0] A_DSTAT = BASE_ADDR + ADDR_W'(OFS_DSTAT);
   localparam logic [ADDR_W-1:0] A_DCTL  = BASE_ADDR + ADDR_W'(OFS_DCTL);

   generate
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("kdi_decode: BASE_ADDR must be word aligned");
      end
   endgenerate

   always_comb begin
      unique case (addr)
         A_KDATA: sel = SEL_KDATA;
         A_KSTAT: sel = SEL_KSTAT;
         A_KCTL:  sel = SEL_KCTL;
         A_DDATA: sel = SEL_DDATA;
         A_DSTAT: sel = SEL_DSTAT;
         A_DCTL:  sel = SEL_DCTL;
         default: sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/kdi_kbd_chan.sv
module kdi_kbd_chan #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_vld,
   input  logic [DATA_W-1:0] char_in,
   input  logic              stat_rd,
   input  logic              ctl_wr,
   input  logic              ctl_bit,
   output logic [DATA_W-1:0] data_q,
   output logic              ready_q,
   output logic              ie_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         ready_q <= 1'b0;
         ie_q    <= 1'b0;
      end else begin
         if (char_vld) data_q <= char_in;
         // a fresh arrival outranks the clearing read
         if (char_vld)     ready_q <= 1'b1;
         else if (stat_rd) ready_q <= 1'b0;
         if (ctl_wr) ie_q <= ctl_bit;
      end
   end

   p_kin_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld |=> ready_q);
   p_kin_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && stat_rd) |=> ready_q);
   p_kin_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !char_vld) |=> !ready_q);
   p_kdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !char_vld |=> $stable(data_q));
endmodule

// File: rtl/kdi_disp_chan.sv
module kdi_disp_chan #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done_in,
   input  logic              stat_rd,
   input  logic              ctl_wr,
   input  logic              ctl_bit,
   output logic [DATA_W-1:0] data_q,
   output logic              ready_q,
   output logic              ie_q,
   output logic              strobe_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         ready_q  <= 1'b1;
         ie_q     <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= data_wr;
         if (data_wr) data_q <= wdata;
         // new character in flight > done of previous > clearing read
         if (data_wr)      ready_q <= 1'b0;
         else if (done_in) ready_q <= 1'b1;
         else if (stat_rd) ready_q <= 1'b0;
         if (ctl_wr) ie_q <= ctl_bit;
      end
   end

   p_strobe_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> (strobe_q && data_q == $past(wdata)));
   p_strobe_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !data_wr |=> !strobe_q);
   p_dout_wrclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !ready_q);
   p_dout_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_in && !data_wr) |=> ready_q);
   p_dout_rdclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !done_in && !data_wr) |=> !ready_q);
endmodule

// File: rtl/kbd_disp_if.sv
module kbd_disp_if
   import kdi_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000,
   parameter int unsigned KIN_BIT   = 1,
   parameter int unsigned DOUT_BIT  = 2,
   parameter int unsigned IE_BIT    = 1,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              kbd_valid,
   input  logic [DATA_W-1:0] kbd_char,
   output logic [DATA_W-1:0] disp_char,
   output logic              disp_strobe,
   input  logic              disp_done,
   output logic              irq
);
   generate
      if (KIN_BIT >= DATA_W || DOUT_BIT >= DATA_W || IE_BIT >= DATA_W) begin : g_bad_bits
         $error("kbd_disp_if: flag bit position outside data width");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("kbd_disp_if: address too narrow for register window");
      end
   endgenerate

   kdi_sel_e          sel;
   logic              kin, kie, dout, die;
   logic [DATA_W-1:0] kdata, ddata;
   logic [DATA_W-1:0] rd_val;

   kdi_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   kdi_kbd_chan #(.DATA_W(DATA_W)) u_kbd (
      .clk      (clk),
      .rst_n    (rst_n),
      .char_vld (kbd_valid),
      .char_in  (kbd_char),
      .stat_rd  (bus_rd && sel == SEL_KSTAT),
      .ctl_wr   (bus_wr && sel == SEL_KCTL),
      .ctl_bit  (bus_wdata[IE_BIT]),
      .data_q   (kdata),
      .ready_q  (kin),
      .ie_q     (kie)
   );

   kdi_disp_chan #(.DATA_W(DATA_W)) u_disp (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (bus_wr && sel == SEL_DDATA),
      .wdata    (bus_wdata),
      .done_in  (disp_done),
      .stat_rd  (bus_rd && sel == SEL_DSTAT),
      .ctl_wr   (bus_wr && sel == SEL_DCTL),
      .ctl_bit  (bus_wdata[IE_BIT]),
      .data_q   (ddata),
      .ready_q  (dout),
      .ie_q     (die),
      .strobe_q (disp_strobe)
   );

   always_comb begin
      rd_val = '0;
      unique case (sel)
         SEL_KDATA: rd_val = kdata;
         SEL_KSTAT: rd_val[KIN_BIT] = kin;
         SEL_KCTL:  rd_val[IE_BIT] = kie;
         SEL_DDATA: rd_val = ddata;
         SEL_DSTAT: rd_val[DOUT_BIT] = dout;
         SEL_DCTL:  rd_val[IE_BIT] = die;
         default:   rd_val = '0;
      endcase
   end

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rdata_q <= '0;
            else if (bus_rd) rdata_q <= rd_val;
         end
         assign bus_rdata = rdata_q;

         p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_rd |=> $stable(bus_rdata));
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? rd_val : '0;
      end
   endgenerate

   assign disp_char = ddata;
   assign irq       = (kin && kie) || (dout && die);

   p_irq_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_KSTAT && !kbd_valid && !(dout && die)
       && !disp_done) |=> !irq);
endmodule

// File: tb/sim_kbd_disp_if.sv
`timescale 1ns/1ps
module sim_kbd_disp_if;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        kbd_valid = 1'b0;
   logic [7:0]  kbd_char = '0;
   logic [7:0]  disp_char;
   logic        disp_strobe;
   logic        disp_done = 1'b0;
   logic        irq;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // model state
   logic       m_kin = 0, m_kie = 0, m_dout = 1, m_die = 0, m_strobe = 0;
   logic [7:0] m_kdata = 0, m_ddata = 0, m_rdata = 0;

   always #4 clk = ~clk;

   kbd_disp_if u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .kbd_valid(kbd_valid), .kbd_char(kbd_char), .disp_char(disp_char),
      .disp_strobe(disp_strobe), .disp_done(disp_done), .irq(irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] read_model(input logic [15:0] a);
      logic [7:0] v = 8'h00;
      case (a)
         16'h4000: v = m_kdata;
         16'h4004: v[1] = m_kin;
         16'h4008: v[1] = m_kie;
         16'h4010: v = m_ddata;
         16'h4014: v[2] = m_dout;
         16'h4018: v[1] = m_die;
         default:  v = 8'h00;
      endcase
      return v;
   endfunction

   function automatic logic model_irq();
      return (m_kin & m_kie) | (m_dout & m_die);
   endfunction

   task automatic compare_all(input string tag);
      check({tag, " R10 rdata"}, bus_rdata, m_rdata);
      check({tag, " R9 irq"}, {7'd0, irq}, {7'd0, model_irq()});
      check({tag, " R5 strobe"}, {7'd0, disp_strobe}, {7'd0, m_strobe});
      check({tag, " R5 disp_char"}, disp_char, m_ddata);
   endtask

   // one bus cycle: drive after negedge, sample at following negedge
   task automatic step(input string tag, input logic kv, input logic [7:0] kc,
                       input logic rd, input logic wr, input logic [15:0] a,
                       input logic [7:0] wd, input logic dn);
      logic [7:0] rv;
      kbd_valid = kv; kbd_char = kc; bus_rd = rd; bus_wr = wr;
      bus_addr = a; bus_wdata = wd; disp_done = dn;
      @(negedge clk);
      rv = read_model(a);
      if (rd) m_rdata = rv;
      if (kv) m_kdata = kc;
      if (kv) m_kin = 1; else if (rd && a == 16'h4004) m_kin = 0;
      if (wr && a == 16'h4008) m_kie = wd[1];
      if (wr && a == 16'h4018) m_die = wd[1];
      if (wr && a == 16'h4010) m_ddata = wd;
      if (wr && a == 16'h4010) m_dout = 0;
      else if (dn) m_dout = 1;
      else if (rd && a == 16'h4014) m_dout = 0;
      m_strobe = wr && a == 16'h4010;
      kbd_valid = 0; bus_rd = 0; bus_wr = 0; disp_done = 0;
      compare_all(tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] amap [0:6];
      int unsigned seed;
      amap[0] = 16'h4000; amap[1] = 16'h4004; amap[2] = 16'h4008;
      amap[3] = 16'h4010; amap[4] = 16'h4014; amap[5] = 16'h4018;
      amap[6] = 16'h400C;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rdata", bus_rdata, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);
      check("R1 disp_char", disp_char, 8'h00);
      check("R1 strobe", {7'd0, disp_strobe}, 8'h00);
      step("R1 kstat", 0, 0, 1, 0, 16'h4004, 0, 0);
      check("R1 kin=0", bus_rdata, 8'h00);
      step("R1 dstat", 0, 0, 1, 0, 16'h4014, 0, 0);
      check("R1 dout=1", bus_rdata, 8'h04);
      // R2 arrival and data readback
      step("R2 arrive", 1, 8'h5A, 0, 0, 0, 0, 0);
      step("R2 kdata", 0, 0, 1, 0, 16'h4000, 0, 0);
      check("R2 kdata", bus_rdata, 8'h5A);
      // R8 enable and R9 irq
      step("R8 kie", 0, 0, 0, 1, 16'h4008, 8'hFD, 0);
      check("R8 kie bit1 only ignored", {7'd0, irq}, 8'h00);
      step("R8 kie", 0, 0, 0, 1, 16'h4008, 8'h02, 0);
      check("R9 irq kbd", {7'd0, irq}, 8'h01);
      step("R8 kctl rd", 0, 0, 1, 0, 16'h4008, 0, 0);
      check("R8 kctl", bus_rdata, 8'h02);
      // R3 status read clears, acknowledges
      step("R3 kstat", 0, 0, 1, 0, 16'h4004, 0, 0);
      check("R3 kin read", bus_rdata, 8'h02);
      check("R3 irq ack", {7'd0, irq}, 8'h00);
      // R4 arrival vs read
      step("R4 collide", 1, 8'h33, 1, 0, 16'h4004, 0, 0);
      check("R4 old value", bus_rdata, 8'h00);
      check("R4 irq kept", {7'd0, irq}, 8'h01);
      // R10 ignored writes
      step("R10 kstat wr", 0, 0, 0, 1, 16'h4004, 8'h00, 0);
      step("R10 kdata wr", 0, 0, 0, 1, 16'h4000, 8'hEE, 0);
      step("R10 unmapped wr", 0, 0, 0, 1, 16'h400C, 8'hFF, 0);
      step("R10 kdata", 0, 0, 1, 0, 16'h4000, 0, 0);
      check("R10 kdata unchanged", bus_rdata, 8'h33);
      step("R10 unmapped rd", 0, 0, 1, 0, 16'h400C, 0, 0);
      check("R10 unmapped", bus_rdata, 8'h00);
      step("R3 clear", 0, 0, 1, 0, 16'h4004, 0, 0);
      // R5 display store
      step("R5 store", 0, 0, 0, 1, 16'h4010, 8'hA7, 0);
      check("R5 strobe hi", {7'd0, disp_strobe}, 8'h01);
      check("R5 char", disp_char, 8'hA7);
      step("R5 idle", 0, 0, 0, 0, 0, 0, 0);
      check("R5 strobe lo", {7'd0, disp_strobe}, 8'h00);
      step("R5 dstat", 0, 0, 1, 0, 16'h4014, 0, 0);
      check("R5 dout cleared", bus_rdata, 8'h00);
      // R6 done sets, store beats done
      step("R8 die", 0, 0, 0, 1, 16'h4018, 8'h02, 0);
      step("R6 done", 0, 0, 0, 0, 0, 0, 1);
      check("R6 irq disp", {7'd0, irq}, 8'h01);
      step("R6 store+done", 0, 0, 0, 1, 16'h4010, 8'h11, 1);
      check("R6 store wins", {7'd0, irq}, 8'h00);
      // R7 done vs read
      step("R7 done+rd", 0, 0, 1, 0, 16'h4014, 0, 1);
      check("R7 old value", bus_rdata, 8'h00);
      check("R7 kept", {7'd0, irq}, 8'h01);
      step("R7 rd", 0, 0, 1, 0, 16'h4014, 0, 0);
      check("R7 read", bus_rdata, 8'h04);
      check("R7 cleared", {7'd0, irq}, 8'h00);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         logic kv, rd, wr, dn;
         int op;
         a  = amap[$urandom % 7];
         kv = ($urandom % 4) == 0;
         dn = ($urandom % 5) == 0;
         op = $urandom % 3;
         rd = (op == 1);
         wr = (op == 2);
         step("R9 random", kv, 8'($urandom), rd, wr, a, 8'($urandom), dn);
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule